// File: doc/BRIEF.md
# Round-Robin Slave Arbiter with Idle Parking and Burst Breaking

This block decides, for a single slave port of a multi-master interconnect, which of up to five masters owns the slave in each cycle. Every master drives a request line and a flag that says it wants to keep the slave for further beats of a burst. The winner among simultaneous requesters is chosen in rotating order, so the master that has just been served becomes the lowest priority for the next decision. The grant is registered: inputs seen in one cycle set the grant for the next cycle.

When no master is requesting, a static policy input decides what happens to the grant. It can be dropped, left on the master that was served last, or parked on a configured master. A parked grant is only a placeholder and gives its master no advantage when real requests arrive. A programmable slot limit caps how many cycles one master may keep the slave in a single burst. When the cap is reached, arbitration runs again and other masters get a turn. A limit of zero removes the cap.

Top module: `slot_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all grant bits are zero.
- R2: At most one grant bit is set in any cycle.
- R3: When arbitration runs and at least one master requests, the next grant goes to the first requesting master found by scanning upward (wrapping at NUM_MASTERS-1) from the master after the one most recently granted on request. After reset the scan starts at master 0.
- R4: While a request-granted master keeps both its request and burst flag high, and it has held the slave for fewer than cfgSlotLimit cycles, its grant stays unchanged.
- R5: A cycle in which the granted master has its request or burst flag low is a transfer boundary. The grant for the next cycle is decided again by R3, or by the idle policy if no master requests.
- R6: With cfgSlotLimit = L > 0, a request-granted master holds the slave for at most L consecutive cycles in one grant. In its L-th cycle, arbitration runs again by R3, starting after that master.
- R7: With cfgSlotLimit = 0, a master holding request and burst flag high keeps the grant for as long as both stay high.
- R8: With cfgMode = 0 or 3 (no parking), a cycle with no request drops every grant bit in the next cycle.
- R9: With cfgMode = 1 (park on last), a cycle with no request leaves the grant for the next cycle on the master most recently granted on request, or on master 0 if none has been granted since reset.
- R10: With cfgMode = 2 (park on fixed), a cycle with no request sets grant bit cfgFixedIdx for the next cycle. If cfgFixedIdx >= NUM_MASTERS, all grant bits drop.
- R11: A parked grant does not hold the slave and does not move the rotation. The next request is arbitrated by R3 in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | NUM_MASTERS | Per-master access request |
| burst | input | NUM_MASTERS | Per-master flag: more beats of the burst follow |
| cfgMode | input | 2 | Idle policy: 0/3 none, 1 last served, 2 fixed master |
| cfgFixedIdx | input | IDX_W | Master index used by the fixed parking policy |
| cfgSlotLimit | input | SLOT_W | Maximum cycles per burst grant, 0 = unlimited |
| grant | output | NUM_MASTERS | Registered one-hot (or zero) grant |

## Verification
The bench targets the slot boundary. A design off by one there would let a bursting master run for L+1 cycles, or cut it after L-1, which shows as a grant change one cycle early or late. Rotation after a slot break is checked with two masters that burst together. A design that rescans from the expired master would regrant it and starve the other. A design that lets a parked grant count as ownership would keep the slave on the parked master while another one is requesting. An out-of-range fixed index is also checked: it must drop the grant rather than decode onto some other master.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } parkMode_e;

  typedef struct packed {
    logic loadBusy;
    logic loadPark;
    logic clear;
    logic incCnt;
  } arbStrobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 5,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] burst,
  input  logic [1:0]             cfgMode,
  input  logic [IDX_W-1:0]       cfgFixedIdx,
  input  logic [SLOT_W-1:0]      cfgSlotLimit,
  input  logic [IDX_W-1:0]       curIdx,
  input  logic                   busy,
  input  logic [IDX_W-1:0]       ptr,
  input  logic [IDX_W-1:0]       lastIdx,
  input  logic [SLOT_W-1:0]      cnt,
  output arbStrobe_t             strb,
  output logic [IDX_W-1:0]       nextIdx
);

  logic             anyReq;
  logic [IDX_W-1:0] rrIdx;
  logic             curReq;
  logic             curBurst;
  logic [SLOT_W:0]  usedNow;
  logic             expire;
  logic             holding;
  logic             fixedOk;

  // rotating scan: lowest offset from ptr wins, so iterate downward
  always_comb begin
    anyReq = 1'b0;
    rrIdx  = '0;
    for (int off = NUM_MASTERS - 1; off >= 0; off--) begin
      int c;
      c = int'(ptr) + off;
      if (c >= NUM_MASTERS) c = c - NUM_MASTERS;
      if (req[c]) begin
        anyReq = 1'b1;
        rrIdx  = IDX_W'(c);
      end
    end
  end

  assign curReq   = req[curIdx];
  assign curBurst = burst[curIdx];
  assign usedNow  = {1'b0, cnt} + 1'b1;
  assign expire   = busy && (cfgSlotLimit != '0) && (usedNow >= {1'b0, cfgSlotLimit});
  assign holding  = busy && curReq && curBurst && !expire;
  assign fixedOk  = int'(cfgFixedIdx) < NUM_MASTERS;

  always_comb begin
    strb    = '0;
    nextIdx = curIdx;
    if (holding) begin
      strb.incCnt = 1'b1;
    end else if (anyReq) begin
      strb.loadBusy = 1'b1;
      nextIdx       = rrIdx;
    end else begin
      case (parkMode_e'(cfgMode))
        PARK_LAST: begin
          strb.loadPark = 1'b1;
          nextIdx       = lastIdx;
        end
        PARK_FIXED: begin
          if (fixedOk) begin
            strb.loadPark = 1'b1;
            nextIdx       = cfgFixedIdx;
          end else begin
            strb.clear = 1'b1;
          end
        end
        default: strb.clear = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 5,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  arbStrobe_t             strb,
  input  logic [IDX_W-1:0]       nextIdx,
  output logic [IDX_W-1:0]       curIdx,
  output logic                   busy,
  output logic [IDX_W-1:0]       ptr,
  output logic [IDX_W-1:0]       lastIdx,
  output logic [SLOT_W-1:0]      cnt,
  output logic [NUM_MASTERS-1:0] grant
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MASTERS - 1);

  logic grantOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx  <= '0;
      grantOn <= 1'b0;
      busy    <= 1'b0;
      ptr     <= '0;
      lastIdx <= '0;
      cnt     <= '0;
    end else begin
      if (strb.loadBusy) begin
        curIdx  <= nextIdx;
        grantOn <= 1'b1;
        busy    <= 1'b1;
        cnt     <= '0;
        lastIdx <= nextIdx;
        ptr     <= (nextIdx == LAST_IDX) ? '0 : nextIdx + 1'b1;
      end else if (strb.loadPark) begin
        curIdx  <= nextIdx;
        grantOn <= 1'b1;
        busy    <= 1'b0;
      end else if (strb.clear) begin
        grantOn <= 1'b0;
        busy    <= 1'b0;
      end else if (strb.incCnt) begin
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_grant
    assign grant[i] = grantOn && (curIdx == IDX_W'(i));
  end

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 5,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] burst,
  input  logic [1:0]             cfgMode,
  input  logic [IDX_W-1:0]       cfgFixedIdx,
  input  logic [SLOT_W-1:0]      cfgSlotLimit,
  output logic [NUM_MASTERS-1:0] grant
);

  arbStrobe_t       strb;
  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] curIdx;
  logic             busyQ;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] lastIdx;
  logic [SLOT_W-1:0] cnt;

  arb_ctrl #(.NUM_MASTERS(NUM_MASTERS), .SLOT_W(SLOT_W)) i_ctrl (
    .req(req), .burst(burst), .cfgMode(cfgMode), .cfgFixedIdx(cfgFixedIdx),
    .cfgSlotLimit(cfgSlotLimit), .curIdx(curIdx), .busy(busyQ), .ptr(ptr),
    .lastIdx(lastIdx), .cnt(cnt), .strb(strb), .nextIdx(nextIdx)
  );

  arb_datapath #(.NUM_MASTERS(NUM_MASTERS), .SLOT_W(SLOT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .nextIdx(nextIdx), .curIdx(curIdx),
    .busy(busyQ), .ptr(ptr), .lastIdx(lastIdx), .cnt(cnt), .grant(grant)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_MASTERS = 5,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_MASTERS-1:0] req,
  input logic [NUM_MASTERS-1:0] burst,
  input logic [1:0]             cfgMode,
  input logic [IDX_W-1:0]       cfgFixedIdx,
  input logic [SLOT_W-1:0]      cfgSlotLimit,
  input logic [NUM_MASTERS-1:0] grant,
  input logic                   busy,
  input logic                   loadBusy
);

  logic [SLOT_W:0] holdLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdLen <= '0;
    else if (loadBusy) holdLen <= 1;
    else if (!busy) holdLen <= '0;
    else if (holdLen != '1) holdLen <= holdLen + 1'b1;
  end

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> grant == '0);

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R4
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && |(grant & req & burst) && cfgSlotLimit != '0 &&
     holdLen < {1'b0, cfgSlotLimit}) |=> $stable(grant));

  // R6
  slot_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgSlotLimit != '0) |-> holdLen <= {1'b0, cfgSlotLimit});

  // R7
  unlimited_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && |(grant & req & burst) && cfgSlotLimit == '0) |=> $stable(grant));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgMode == 2'd0 || cfgMode == 2'd3) && req == '0) |=> grant == '0);

  // R10
  fixed_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd2 && req == '0 && int'(cfgFixedIdx) < NUM_MASTERS)
      |=> grant == (NUM_MASTERS'(1) << $past(cfgFixedIdx)));

endmodule

bind slot_arbiter arb_checker #(.NUM_MASTERS(NUM_MASTERS), .SLOT_W(SLOT_W)) i_chk (
  .clk(clk), .rstN(rstN), .req(req), .burst(burst), .cfgMode(cfgMode),
  .cfgFixedIdx(cfgFixedIdx), .cfgSlotLimit(cfgSlotLimit), .grant(grant),
  .busy(busyQ), .loadBusy(strb.loadBusy)
);

// File: tb/test_slot_arbiter.sv
`timescale 1ns/1ps
module test_slot_arbiter;

  localparam int N = 5;
  localparam int SW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  burst = '0;
  logic [1:0]    cfgMode = 2'd0;
  logic [IW-1:0] cfgFixedIdx = '0;
  logic [SW-1:0] cfgSlotLimit = '0;
  logic [N-1:0]  grant;

  int nChecks = 0;
  int nFails = 0;

  // reference model state
  int mCur = 0, mOn = 0, mBusy = 0, mPtr = 0, mLast = 0, mCnt = 0;
  logic [N-1:0] expGrant = '0;
  string expTag = "R1";

  always #2 clk = ~clk;

  slot_arbiter #(.NUM_MASTERS(N), .SLOT_W(SW)) i_slot_arbiter (
    .clk(clk), .rstN(rstN), .req(req), .burst(burst), .cfgMode(cfgMode),
    .cfgFixedIdx(cfgFixedIdx), .cfgSlotLimit(cfgSlotLimit), .grant(grant)
  );

  task automatic modelStep();
    int lim;
    bit exp;
    int pick;
    if (!rstN) begin
      mCur = 0; mOn = 0; mBusy = 0; mPtr = 0; mLast = 0; mCnt = 0;
      expTag = "R1";
    end else begin
      lim = int'(cfgSlotLimit);
      exp = (mBusy != 0) && lim != 0 && (mCnt + 1 >= lim);
      if (mBusy != 0 && req[mCur] && burst[mCur] && !exp) begin
        mCnt++;
        expTag = (lim == 0) ? "R7" : "R4";
      end else begin
        pick = -1;
        for (int k = 0; k < N; k++) begin
          int idx;
          idx = (mPtr + k) % N;
          if (req[idx] && pick < 0) pick = idx;
        end
        if (pick >= 0) begin
          if (mBusy != 0 && exp) expTag = "R6";
          else if (mOn != 0 && mBusy == 0) expTag = "R11";
          else if (mBusy != 0) expTag = "R5";
          else expTag = "R3";
          mCur = pick; mOn = 1; mBusy = 1; mCnt = 0;
          mPtr = (pick + 1) % N; mLast = pick;
        end else if (cfgMode == 2'd1) begin
          mCur = mLast; mOn = 1; mBusy = 0; expTag = "R9";
        end else if (cfgMode == 2'd2) begin
          expTag = "R10";
          mBusy = 0;
          if (int'(cfgFixedIdx) < N) begin mCur = int'(cfgFixedIdx); mOn = 1; end
          else mOn = 0;
        end else begin
          mOn = 0; mBusy = 0; expTag = "R8";
        end
      end
    end
    expGrant = (mOn != 0) ? (N'(1) << mCur) : '0;
  endtask

  task automatic tick();
    modelStep();
    @(negedge clk);
    nChecks++;
    if (grant !== expGrant) begin
      nFails++;
      $display("FAIL %s: grant actual %b expected %b at %0t", expTag, grant, expGrant, $time);
    end
    nChecks++;
    if ($countones(grant) > 1) begin
      nFails++;
      $display("FAIL R2: grant actual %b expected at most one bit set", grant);
    end
  endtask

  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] b, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      req = r; burst = b;
      tick();
    end
  endtask

  task automatic setCfg(input logic [1:0] m, input logic [IW-1:0] f, input logic [SW-1:0] l);
    drive('0, '0, 2);
    cfgMode = m; cfgFixedIdx = f; cfgSlotLimit = l;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not end, actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin : main
    // R1: reset held
    drive('0, '0, 3);
    rstN = 1'b1;
    drive('0, '0, 2);
    // R3 R5: two single-beat requesters alternate
    drive(5'b01010, 5'b00000, 8);
    // R7: long burst with no limit while another waits
    drive(5'b10100, 5'b00100, 30);
    drive(5'b10000, 5'b00000, 2);
    // R6: limit 3, two masters bursting together
    setCfg(2'd0, '0, 8'd3);
    drive(5'b00011, 5'b00011, 18);
    // R6: limit 1, single bursting master is regranted
    setCfg(2'd0, '0, 8'd1);
    drive(5'b01000, 5'b01000, 5);
    // R9 R11: park on last, then a new requester
    setCfg(2'd1, '0, 8'd4);
    drive('0, '0, 3);
    drive(5'b00001, 5'b00001, 6);
    // R10: park on fixed, in and out of range
    setCfg(2'd2, 3'd4, 8'd2);
    drive('0, '0, 3);
    drive(5'b00010, 5'b00000, 2);
    setCfg(2'd2, 3'd6, 8'd2);
    drive('0, '0, 3);
    // R8: reserved mode behaves as no parking
    setCfg(2'd3, 3'd1, 8'd0);
    drive(5'b00100, 5'b00000, 2);
    drive('0, '0, 3);
    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      logic [N-1:0] r;
      logic [N-1:0] b;
      setCfg(2'(ph % 4), 3'(ph % 7), 8'((ph * 3) % 6));
      r = '0; b = '0;
      for (int c = 0; c < 400; c++) begin
        for (int m = 0; m < N; m++) begin
          if (!r[m]) r[m] = ($urandom % 100) < 20;
          else if (($urandom % 100) < 15) r[m] = 1'b0;
          b[m] = r[m] && (($urandom % 100) < 80);
        end
        drive(r, b, 1);
      end
    end
    disable watchdog;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule